// File: doc/BRIEF.md
# Multi-Phase PWM Channel Rotator

This block drives four PWM outputs (channels A, B, C, D) from one shared up-counter. The counter runs from zero to a programmable period value and wraps. Each channel has its own compare value, and its output is high while the counter is below that value. A phase mode can gate the channels through a one-hot rotating enable register. In that case only one channel, or one adjacent pair, is allowed to pulse in each counter period, and the enabled slot moves by one place every time the counter wraps. The rotation can run in either direction.

The phase mode is held in a register that accepts writes only while the timer is stopped. The direction input is used live, so a change takes effect at the next wrap. A channel whose PWM enable is low stays low, but it keeps its place in the rotation. Some periods can therefore carry no pulse on any pin.

Top module: `mphase_pwm`

## Requirements
- R1: While `run_i` is high, the counter counts 0, 1, ... up to `top_i` and then returns to 0, so one period is `top_i`+1 cycles. An enabled, gated-in channel is high in exactly the cycles where the counter is below its compare value: compare 0 never pulses, and a compare above `top_i` pulses for the whole period.
- R2: Mode code 000 (and the unused codes 101, 110, 111) gates nothing: every PWM-enabled channel pulses in every period.
- R3: Mode code 001: A and B alternate, one per period, and C and D run as in R2.
- R4: Mode code 010: A, B and C take turns, one per period, and D runs as in R2.
- R5: Mode code 011: exactly one of A, B, C, D is gated in per period, and the gated-in channel moves one step at each counter wrap.
- R6: Mode code 100: an adjacent pair is gated in. The sequence is AB, BC, CD, DA with `dir_i`=0, and the pair moves by one channel per period.
- R7: `dir_i`=0 advances the rotation A→B→C→D. `dir_i`=1 advances it D→C→B→A. A change of `dir_i` during a run applies at the next wrap.
- R8: A channel that is gated out stays low for its whole period, whatever its compare value.
- R9: A channel with its `pwm_en_i` bit low stays low, but it still holds its slot, so that period has no pulse on any gated channel.
- R10: `mode_we_i` loads `mode_i` only while `run_i` is low. A write while the timer runs is ignored, and the old mode stays in force.
- R11: While `run_i` is low, all outputs are low and the counter is held at 0. The first period after the timer starts gates in A (the AB pair in mode 100).
- R12: After reset, the mode is 000 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Timer run bit |
| top_i | input | CNT_W | Period (TOP) value |
| cmp_i | input | 4*CNT_W | Compare values, channel A in the low bits |
| pwm_en_i | input | 4 | PWM enable per channel, bit 0 = A |
| mode_we_i | input | 1 | Phase-mode write strobe |
| mode_i | input | 3 | Phase-mode value to write |
| dir_i | input | 1 | Rotation direction, 0 = forward |
| pwm_o | output | 4 | PWM outputs, bit 0 = A |

## Verification
The rotation register is internal, and its only visible effect is which pin pulses in each period. If the register lost its single set bit, or stepped at the wrong time or in the wrong ring length, the pulse would appear on the wrong pin or on several pins at the start of the next period, so the error shows within one period. If a mode write leaked in during a run, the ring length would change, and the pin sequence would differ from the model within a few periods. The per-cycle scoreboard compares all four pins on every cycle, so a wrong pulse width or a wrong pulse position is reported on the cycle where it happens.

// File: rtl/mphase_pwm_pkg.sv
package mphase_pwm_pkg;
  localparam int unsigned NCH = 4;

  typedef enum logic [2:0] {
    PH_OFF  = 3'b000,
    PH_1OF2 = 3'b001,
    PH_1OF3 = 3'b010,
    PH_1OF4 = 3'b011,
    PH_2OF4 = 3'b100
  } ph_mode_e;
endpackage

// File: rtl/mphase_pwm_timer.sv
module mphase_pwm_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == top_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mphase_pwm_rotor.sv
module mphase_pwm_rotor
  import mphase_pwm_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           wrap_i,
  input  logic           dir_i,
  input  logic [2:0]     mode_i,
  output logic [NCH-1:0] rot_o,
  output logic [NCH-1:0] gate_o
);
  logic [NCH-1:0] rot_q, fwd_n, rev_n;
  logic [1:0]     last;
  logic           rotating;

  always_comb begin
    rotating = 1'b1;
    last     = 2'd3;
    unique case (mode_i)
      PH_1OF2: last = 2'd1;
      PH_1OF3: last = 2'd2;
      PH_1OF4,
      PH_2OF4: last = 2'd3;
      default: rotating = 1'b0;
    endcase
    // ring of length last+1 inside the low bits
    fwd_n = rot_q[last] ? 4'b0001 : (rot_q << 1);
    rev_n = rot_q[0] ? (4'b0001 << last) : (rot_q >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rot_q <= 4'b0001;
    else if (!run_i)             rot_q <= 4'b0001;
    else if (wrap_i && rotating) rot_q <= dir_i ? rev_n : fwd_n;
  end

  always_comb begin
    unique case (mode_i)
      PH_1OF2: gate_o = {2'b11, rot_q[1:0]};
      PH_1OF3: gate_o = {1'b1, rot_q[2:0]};
      PH_1OF4: gate_o = rot_q;
      PH_2OF4: gate_o = rot_q | {rot_q[2:0], rot_q[3]};
      default: gate_o = '1;
    endcase
  end

  assign rot_o = rot_q;
endmodule

// File: rtl/mphase_pwm_chan.sv
module mphase_pwm_chan #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             run_i,
  input  logic             pwm_en_i,
  input  logic             gate_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             pwm_o
);
  // gated-out channel: match blocked, output held low
  assign pwm_o = run_i && pwm_en_i && gate_i && (cnt_i < cmp_i);
endmodule

// File: rtl/mphase_pwm.sv
module mphase_pwm
  import mphase_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [CNT_W-1:0]     top_i,
  input  logic [4*CNT_W-1:0]   cmp_i,
  input  logic [3:0]           pwm_en_i,
  input  logic                 mode_we_i,
  input  logic [2:0]           mode_i,
  input  logic                 dir_i,
  output logic [3:0]           pwm_o
);
  logic [2:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;
  logic [NCH-1:0]   rot_q, gate;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mode_q <= PH_OFF;
    else if (mode_we_i && !run_i)  mode_q <= mode_i;
  end

  mphase_pwm_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .run_i, .top_i,
    .cnt_o(cnt_q), .wrap_o(wrap)
  );

  mphase_pwm_rotor u_rotor (
    .clk_i, .rst_ni, .run_i,
    .wrap_i(wrap), .dir_i, .mode_i(mode_q),
    .rot_o(rot_q), .gate_o(gate)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mphase_pwm_chan #(.CNT_W(CNT_W)) u_ch (
      .run_i,
      .pwm_en_i(pwm_en_i[i]),
      .gate_i(gate[i]),
      .cnt_i(cnt_q),
      .cmp_i(cmp_i[i*CNT_W +: CNT_W]),
      .pwm_o(pwm_o[i])
    );
  end
endmodule

// File: rtl/mphase_pwm_chk.sv
module mphase_pwm_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [CNT_W-1:0] top_i,
  input logic [3:0]       pwm_en_i,
  input logic [3:0]       pwm_o,
  input logic [3:0]       rot_q,
  input logic [2:0]       mode_q,
  input logic [CNT_W-1:0] cnt_q
);
  AST_ROT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rot_q) == 1); // R5

  AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) |-> $stable(mode_q)); // R10

  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (pwm_o == 4'b0000)); // R11

  AST_NOPWM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_o & ~pwm_en_i) == 4'b0000); // R9

  AST_ROT_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (cnt_q != top_i) |=> $stable(rot_q)); // R1
endmodule

bind mphase_pwm mphase_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .top_i(top_i),
  .pwm_en_i(pwm_en_i), .pwm_o(pwm_o), .rot_q(rot_q),
  .mode_q(mode_q), .cnt_q(cnt_q)
);

// File: tb/mphase_pwm_bench.sv
module mphase_pwm_bench;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           run = 1'b0;
  logic [W-1:0]   top = 8'd5;
  logic [4*W-1:0] cmp = {8'd4, 8'd3, 8'd2, 8'd1};
  logic [3:0]     pen = 4'hF;
  logic           we = 1'b0;
  logic [2:0]     mode_in = 3'b000;
  logic           dir = 1'b0;
  logic [3:0]     pwm;

  int checks = 0;
  int errors = 0;
  string req = "R12";
  bit done = 1'b0;

  always #2 clk = ~clk;

  mphase_pwm #(.CNT_W(W)) u_mphase_pwm (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .top_i(top), .cmp_i(cmp),
    .pwm_en_i(pen), .mode_we_i(we), .mode_i(mode_in), .dir_i(dir), .pwm_o(pwm)
  );

  // reference model: index-based, independent of the one-hot form
  logic [2:0] m_mode;
  int         m_cnt, m_pos;

  function automatic int ring_len(logic [2:0] md);
    case (md)
      3'b001:  return 2;
      3'b010:  return 3;
      3'b011,
      3'b100:  return 4;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] exp_out();
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      bit g;
      case (m_mode)
        3'b001:  g = (i >= 2) || (i == m_pos);
        3'b010:  g = (i == 3) || (i == m_pos);
        3'b011:  g = (i == m_pos);
        3'b100:  g = (i == m_pos) || (i == (m_pos + 1) % 4);
        default: g = 1'b1;
      endcase
      r[i] = run && pen[i] && g && (m_cnt < int'(cmp[i*W +: W]));
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 3'b000; m_cnt <= 0; m_pos <= 0;
    end else begin
      if (we && !run) m_mode <= mode_in;
      if (!run) begin
        m_cnt <= 0; m_pos <= 0;
      end else if (m_cnt == int'(top)) begin
        int l;
        l = ring_len(m_mode);
        m_cnt <= 0;
        if (l != 0) m_pos <= dir ? (m_pos + l - 1) % l : (m_pos + 1) % l;
      end else m_cnt <= m_cnt + 1;
    end
  end

  // scoreboard
  logic [3:0] exp_q[$];

  always @(negedge clk) if (rst_n) exp_q.push_back(exp_out());

  always @(negedge clk) begin
    #0.5;
    if (rst_n && exp_q.size() > 0) begin
      logic [3:0] e;
      e = exp_q.pop_front();
      checks++;
      if (pwm !== e) begin
        errors++;
        $display("FAIL %s pwm=%b expected=%b t=%0t", req, pwm, e, $time);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_mode(logic [2:0] md);
    mode_in = md; we = 1'b1; tick(1); we = 1'b0;
  endtask

  task automatic run_periods(int n);
    run = 1'b1; tick(n * (int'(top) + 1));
  endtask

  task automatic stop();
    run = 1'b0; tick(2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    tick(3);
    checks++; // R12: outputs low during reset
    if (pwm !== 4'b0000) begin
      errors++; $display("FAIL R12 pwm=%b expected=0000", pwm);
    end
    rst_n = 1'b1;
    tick(2);
    req = "R2"; run_periods(3); stop();       // R12 mode off after reset, R1 widths
    req = "R3"; set_mode(3'b001);
    dir = 0; run_periods(5); stop();
    dir = 1; run_periods(5); stop();
    req = "R4"; set_mode(3'b010);
    dir = 0; run_periods(7); stop();
    dir = 1; run_periods(7); stop();
    req = "R5"; set_mode(3'b011);
    dir = 0; run_periods(9); stop();
    dir = 1; run_periods(9); stop();
    req = "R6"; set_mode(3'b100);
    dir = 0; run_periods(9); stop();
    dir = 1; run_periods(9); stop();
    req = "R7"; set_mode(3'b011);             // direction flip mid-run
    dir = 0; run = 1'b1; tick(2 * 6 + 3);
    dir = 1; tick(3 * 6);
    dir = 0; tick(6 + 2); stop();
    req = "R9"; pen = 4'b1101;                // B not PWM, keeps slot
    run_periods(8); pen = 4'hF; stop();
    req = "R10"; set_mode(3'b001); run = 1'b1; tick(4);
    mode_in = 3'b011; we = 1'b1; tick(1); we = 1'b0;   // ignored write
    tick(5 * 6); stop();
    req = "R2"; set_mode(3'b101); run_periods(3); stop();
    req = "R8"; set_mode(3'b011);             // extreme compare values
    cmp = {8'd0, 8'd9, 8'd6, 8'd0}; run_periods(8); stop();
    req = "R1"; top = 8'd0; cmp = {8'd1, 8'd0, 8'd1, 8'd1};
    run_periods(8); stop();
    top = 8'd12; cmp = {8'd12, 8'd7, 8'd3, 8'd13}; set_mode(3'b100);
    run_periods(6); stop();
    req = "R11"; set_mode(3'b010); run_periods(2);
    run = 1'b0; tick(1);
    checks++; // R11: stop forces outputs low
    if (pwm !== 4'b0000) begin
      errors++; $display("FAIL R11 pwm=%b expected=0000", pwm);
    end
    run_periods(2); stop();                   // restart begins at A
    tick(2);
    finish_run();
  end
endmodule